// File: doc/BRIEF.md
# Shared Address/Data Byte-Bus Register Slave

This block is the slave side of a byte-wide register bus. One 8-bit set of lines carries the register address first and then the data. A master sets up a cycle by driving an address and pulsing the address latch enable high and then low. It then raises a read or a write: it pulls chip select low together with either the read strobe or the write strobe. All bus pins are asynchronous to the block. They are resynchronised to a fast internal clock, and every decision the block makes comes from edges seen on that clock.

A write is committed when the write strobe rises while chip select is low. At that moment the block emits a one-cycle `wr_valid` beat that carries `reg_addr` and `wr_data`. A read opens when chip select and the read strobe are both low. The block then freezes the selected register's value, drives it on `ad_out` with `ad_oe` high, and emits a one-cycle `rd_valid` beat so that read-sensitive registers can react. The beats have no ready input, because a bus master cannot be stalled, so any consumer must accept every beat. A small example bank sits behind the decoder. It holds read/write registers and a sticky event register that is cleared by being read.

Top module: `adbus_slave`

## Requirements
- R1: After reset `ad_oe`, `wr_valid` and `rd_valid` are 0, `ad_out` and `reg_addr` are 0x00, and every bank register reads 0x00.
- R2: `reg_addr` takes the value on `ad_in` at the high-to-low transition of `ale`. Later changes on `ad_in` while `ale` stays low leave `reg_addr` unchanged.
- R3: A rising `wr_n` while `cs_n` is low gives exactly one `wr_valid` cycle. That cycle carries the latched address and the `ad_in` byte, and a read/write bank register at that address then holds the byte.
- R4: A `wr_n` pulse while `cs_n` is high gives no `wr_valid` and changes no register.
- R5: While `cs_n` and `rd_n` are both low, `ad_oe` is 1 and `ad_out` holds the value the addressed register had when the read opened.
- R6: `ad_oe` returns to 0 within 3 clock cycles after either `cs_n` or `rd_n` goes high, and it never rises while `cs_n` is high.
- R7: Each read opening gives exactly one `rd_valid` cycle, with `reg_addr` equal to the latched address.
- R8: The bank has NREG registers at addresses 0..NREG-1 (default 4). Addresses 0..NREG-2 are read/write. Address NREG-1 (default 3) is the event register: each `evt_in` bit that is high in a cycle sets the matching sticky bit. A read of this register returns the sticky bits and then clears them, except that bits whose `evt_in` is still high at the clearing edge stay set. Writes to this register are ignored.
- R9: A read of an address at or above NREG returns 0x00. A write to such an address still produces its `wr_valid` beat but changes no bank register.
- R10: `wr_valid` and `rd_valid` are never high in the same cycle. A write strobe that rises while a read is open is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale | input | 1 | Address latch enable; the address is taken on its falling edge |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; the write commits on its rising edge |
| ad_in | input | 8 | Shared address/data lines as seen by the block |
| ad_out | output | 8 | Read data for the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| evt_in | input | 8 | Event bits that set the sticky event register |
| reg_addr | output | 8 | Latched register address |
| wr_valid | output | 1 | One-cycle write beat |
| wr_data | output | 8 | Write byte that goes with `wr_valid` |
| rd_valid | output | 1 | One-cycle read beat |

## Verification
The hardest case to reach from the ports is an event that arrives while its own sticky bit is being cleared by a read. The edge that opens the read depends on two synchronizer stages, so pulsing `evt_in` by itself cannot hit that edge reliably. The stimulus therefore holds an event bit high for the whole read. That bit is then guaranteed to be present at the clearing edge, and two follow-up reads show the bit surviving once and then vanishing after the event is released. Address stability is probed by changing `ad_in` after `ale` falls and before every strobe.

// File: rtl/adbus_pkg.sv
package adbus_pkg;
  localparam int unsigned ADW = 8;

  typedef struct packed {
    logic           ale;
    logic           cs_n;
    logic           rd_n;
    logic           wr_n;
    logic [ADW-1:0] ad;
  } pins_t;

  localparam int unsigned PINS_W = $bits(pins_t);

  localparam pins_t PINS_IDLE = '{ale: 1'b0, cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, ad: '0};
endpackage

// File: rtl/adbus_sync.sv
module adbus_sync #(
  parameter int unsigned W      = 12,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= RST_VAL;
    else        stage_q[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= RST_VAL;
      else        stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/adbus_cycle_dec.sv
module adbus_cycle_dec
  import adbus_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  pins_t          pin_s,
  input  logic [ADW-1:0] rd_data,
  output logic [ADW-1:0] addr,
  output logic           wr_valid,
  output logic [ADW-1:0] wr_data,
  output logic           rd_take,
  output logic           rd_valid,
  output logic           oe,
  output logic [ADW-1:0] ad_out
);
  pins_t prev_q;
  logic  ale_fall;
  logic  wr_rise;
  logic  sel_now;
  logic  wr_ok;

  assign ale_fall = prev_q.ale & ~pin_s.ale;
  assign wr_rise  = ~prev_q.wr_n & pin_s.wr_n;
  assign sel_now  = ~pin_s.cs_n & ~pin_s.rd_n;
  assign wr_ok    = wr_rise & ~pin_s.cs_n & ~sel_now & ~oe;
  assign rd_take  = sel_now & ~oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= PINS_IDLE;
      addr     <= '0;
      wr_valid <= 1'b0;
      wr_data  <= '0;
      rd_valid <= 1'b0;
      oe       <= 1'b0;
      ad_out   <= '0;
    end else begin
      prev_q   <= pin_s;
      wr_valid <= wr_ok;
      rd_valid <= rd_take;
      oe       <= sel_now;
      if (ale_fall) addr    <= pin_s.ad;
      if (wr_ok)    wr_data <= pin_s.ad;
      if (rd_take)  ad_out  <= rd_data;
    end
  end

  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(prev_q.ale && !pin_s.ale) |=> $stable(addr))
    else $error("a_r2_addr_hold");

  a_r3_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid)
    else $error("a_r3_wr_single");

  a_r7_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid)
    else $error("a_r7_rd_single");

  a_r6_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    pin_s.cs_n |=> !oe)
    else $error("a_r6_oe_needs_cs");

  a_r10_beats_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_valid))
    else $error("a_r10_beats_exclusive");
endmodule

// File: rtl/adbus_regbank.sv
module adbus_regbank
  import adbus_pkg::*;
#(
  parameter int unsigned NREG = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [ADW-1:0] addr,
  input  logic           wr_valid,
  input  logic [ADW-1:0] wr_data,
  input  logic           rd_take,
  input  logic [ADW-1:0] evt_in,
  output logic [ADW-1:0] rd_data
);
  localparam int unsigned NRW      = NREG - 1;
  localparam int unsigned STAT_IDX = NREG - 1;

  logic [ADW-1:0] rw_q [NRW];
  logic [ADW-1:0] stat_q;
  logic           stat_sel;
  logic           stat_clr;

  assign stat_sel = (addr == ADW'(STAT_IDX));
  assign stat_clr = rd_take & stat_sel;

  for (genvar i = 0; i < NRW; i++) begin : g_rw
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                rw_q[i] <= '0;
      else if (wr_valid && addr == ADW'(i))      rw_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stat_q <= '0;
    else if (stat_clr) stat_q <= evt_in;
    else               stat_q <= stat_q | evt_in;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NRW; i++) begin
      if (addr == ADW'(i)) rd_data = rw_q[i];
    end
    if (stat_sel) rd_data = stat_q;
  end

  a_r8_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && evt_in == '0) |=> (stat_q == '0))
    else $error("a_r8_clear_on_read");

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr |=> ((stat_q & $past(stat_q)) == $past(stat_q)))
    else $error("a_r8_sticky");
endmodule

// File: rtl/adbus_slave.sv
module adbus_slave
  import adbus_pkg::*;
#(
  parameter int unsigned NREG        = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ale,
  input  logic           cs_n,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [ADW-1:0] ad_in,
  output logic [ADW-1:0] ad_out,
  output logic           ad_oe,
  input  logic [ADW-1:0] evt_in,
  output logic [ADW-1:0] reg_addr,
  output logic           wr_valid,
  output logic [ADW-1:0] wr_data,
  output logic           rd_valid
);
  pins_t          pin_raw;
  pins_t          pin_s;
  logic [ADW-1:0] rd_data;
  logic           rd_take;

  assign pin_raw = '{ale: ale, cs_n: cs_n, rd_n: rd_n, wr_n: wr_n, ad: ad_in};

  adbus_sync #(
    .W       (PINS_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PINS_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_raw),
    .q     (pin_s)
  );

  adbus_cycle_dec u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_s    (pin_s),
    .rd_data  (rd_data),
    .addr     (reg_addr),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .rd_take  (rd_take),
    .rd_valid (rd_valid),
    .oe       (ad_oe),
    .ad_out   (ad_out)
  );

  adbus_regbank #(
    .NREG (NREG)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (reg_addr),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .rd_take  (rd_take),
    .evt_in   (evt_in),
    .rd_data  (rd_data)
  );
endmodule

// File: tb/adbus_slave_tb.sv
`timescale 1ns/1ps
module adbus_slave_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ale = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] ad_in = 8'h00, evt_in = 8'h00;
  logic [7:0] ad_out, reg_addr, wr_data;
  logic       ad_oe, wr_valid, rd_valid;

  int checks = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0, cyc = 0;
  logic [7:0] last_wa = 0, last_wd = 0, last_ra = 0;
  logic both_seen = 1'b0, oe_no_cs = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adbus_slave u_dut (
    .clk(clk), .rst_n(rst_n), .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .evt_in(evt_in),
    .reg_addr(reg_addr), .wr_valid(wr_valid), .wr_data(wr_data), .rd_valid(rd_valid)
  );

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (wr_valid) begin wr_cnt++; last_wa = reg_addr; last_wd = wr_data; end
      if (rd_valid) begin rd_cnt++; last_ra = reg_addr; end
      if (wr_valid && rd_valid) both_seen = 1'b1;
    end
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Latch an address, then put junk on the lines (R2 probe)
  task automatic set_addr(input logic [7:0] a);
    ad_in = a; ale = 1'b1; idle(4);
    ale = 1'b0; idle(4);
    ad_in = ~a; idle(4);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input bit use_cs);
    set_addr(a);
    ad_in = d; cs_n = !use_cs; idle(3);
    wr_n = 1'b0; idle(4);
    wr_n = 1'b1; idle(4);
    cs_n = 1'b1; idle(3);
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] got);
    int rc;
    set_addr(a);
    rc = rd_cnt;
    check("R2 address held after ale fall", reg_addr, a);
    cs_n = 1'b0; rd_n = 1'b0; idle(5);
    check("R5 oe during read", ad_oe, 1'b1);
    got = ad_out;
    rd_n = 1'b1; idle(3);
    check("R6 oe released after rd_n rise", ad_oe, 1'b0);
    cs_n = 1'b1; idle(3);
    check("R7 one rd_valid per read", rd_cnt - rc, 1);
    check("R7 rd_valid address", last_ra, a);
  endtask

  // op: 0 write with cs, 1 read (data = expected), 2 write with cs high
  localparam int NV = 14;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 8'h00, 8'h11}, {2'd0, 8'h01, 8'h22}, {2'd0, 8'h02, 8'h33},
    {2'd1, 8'h00, 8'h11}, {2'd1, 8'h01, 8'h22}, {2'd1, 8'h02, 8'h33},
    {2'd2, 8'h01, 8'hEE}, {2'd1, 8'h01, 8'h22},
    {2'd0, 8'h07, 8'h44}, {2'd1, 8'h07, 8'h00},
    {2'd0, 8'h03, 8'hFF}, {2'd1, 8'h03, 8'h00},
    {2'd0, 8'h00, 8'hA5}, {2'd1, 8'h00, 8'hA5}
  };

  initial begin
    logic [7:0] got;
    idle(3);
    // R1 reset state
    check("R1 ad_oe", ad_oe, 0);
    check("R1 ad_out", ad_out, 0);
    check("R1 reg_addr", reg_addr, 0);
    check("R1 beats", {wr_valid, rd_valid}, 0);
    rst_n = 1'b1; idle(4);
    for (int i = 0; i < 3; i++) begin
      do_read(8'(i), got);
      check("R1 bank register after reset", got, 0);
    end

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op; logic [7:0] a, d; int wc;
      {op, a, d} = VEC[i];
      wc = wr_cnt;
      case (op)
        2'd0: begin
          do_write(a, d, 1'b1);
          check("R3 one wr_valid per write", wr_cnt - wc, 1);
          check("R3 wr beat addr/data", {last_wa, last_wd}, {a, d});
        end
        2'd1: begin
          do_read(a, got);
          check(a >= 8'd3 ? "R9/R8 read of unmapped or status" : "R5 read data", got, d);
        end
        default: begin
          do_write(a, d, 1'b0);
          check("R4 no wr_valid without cs", wr_cnt - wc, 0);
        end
      endcase
    end

    // R6: oe released by cs_n rising while rd_n stays low
    set_addr(8'h00);
    cs_n = 1'b0; rd_n = 1'b0; idle(5);
    check("R6 oe on", ad_oe, 1);
    cs_n = 1'b1; idle(3);
    check("R6 oe released after cs_n rise", ad_oe, 0);
    idle(4);
    check("R6 oe stays low with cs_n high", ad_oe, 0);
    rd_n = 1'b1; idle(3);

    // R10: write strobe pulsed during an open read is ignored
    begin
      int wc;
      set_addr(8'h01);
      wc = wr_cnt;
      cs_n = 1'b0; rd_n = 1'b0; idle(5);
      ad_in = 8'h99; wr_n = 1'b0; idle(4); wr_n = 1'b1; idle(4);
      rd_n = 1'b1; idle(3); cs_n = 1'b1; idle(3);
      check("R10 no write during read", wr_cnt - wc, 0);
      do_read(8'h01, got);
      check("R10 register unchanged", got, 8'h22);
    end

    // R8: sticky events, clear on read, held event survives the clear
    evt_in = 8'h05; idle(1); evt_in = 8'h00; idle(1);
    evt_in = 8'h40; idle(1); evt_in = 8'h00; idle(2);
    do_read(8'h03, got);
    check("R8 sticky bits accumulate", got, 8'h45);
    do_read(8'h03, got);
    check("R8 cleared by read", got, 8'h00);
    evt_in = 8'h01;
    do_read(8'h03, got);
    check("R8 held event read", got, 8'h01);
    evt_in = 8'h00; idle(2);
    do_read(8'h03, got);
    check("R8 held event survives clear", got, 8'h01);
    do_read(8'h03, got);
    check("R8 cleared after event released", got, 8'h00);

    check("R10 beats never overlap", both_seen, 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule